// File: doc/BRIEF.md
# Codec Register Access Port

This block gives the host one 32-bit command/status word for reaching the 16-bit registers of an external audio codec. When the port is idle, a host write of that word starts a transaction. The write carries a 7-bit codec register index, a direction bit and 16 bits of data. The port raises a request toward a codec-link engine and holds the command fields steady until the engine answers with a done pulse. For a read, the done pulse also carries the codec's 16-bit value.

The host polls the same word to see progress. A busy flag shows that a command is in flight. A valid flag shows that read data from the codec has arrived in the low 16 bits. A sticky collision flag records any host write that arrived while busy; such writes are dropped. A cycle limit, driven from an input, ends a transaction whose done never arrives. Busy then clears and valid stays low, so software can tell that the read produced nothing.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, `host_rdata_o` reads 0 and `link_req_o` is low. Bits 31:27 of the word always read 0.
- R2: A host write while not busy is accepted. The port captures bits 22:16 as the codec index, bit 23 as the direction (1 = read) and bits 15:0 as data. From the next cycle `link_req_o` is high, the link outputs carry those fields, and busy (bit 24) reads 1.
- R3: `link_req_o` and the link fields stay unchanged while busy. A `link_done_i` pulse seen while busy clears busy and the request from the next cycle.
- R4: When a read completes, bits 15:0 take the value on `link_rdata_i` in the done cycle, and valid (bit 25) is set.
- R5: When a write completes, bits 15:0 keep the written data and valid stays 0.
- R6: Accepting any new command clears valid from the next cycle.
- R7: A host write while busy changes neither the command fields nor the link outputs. It sets the collision flag (bit 26).
- R8: The collision flag stays set until a command is accepted with bit 26 written as 1. An accepted command with bit 26 at 0 leaves the flag set.
- R9: If `tmo_limit_i` is N > 0 and no done arrives, busy lasts exactly N cycles and then clears. Valid stays 0 and the data field is unchanged.
- R10: If `tmo_limit_i` is 0, a pending command waits for done without limit.
- R11: A `link_done_i` pulse while idle leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the command word |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Command/status word as read by the host |
| tmo_limit_i | input | TMO_W | Busy-cycle limit, 0 disables it |
| link_req_o | output | 1 | Request to the codec-link engine, high while busy |
| link_rd_o | output | 1 | Direction of the pending command, 1 = read |
| link_idx_o | output | 7 | Codec register index |
| link_wdata_o | output | 16 | Data field of the pending command |
| link_done_i | input | 1 | Completion pulse from the link engine |
| link_rdata_i | input | 16 | Codec read value, valid with done |

## Verification
A table of commands mixes reads and writes. Their indices span the ends of the 7-bit range, and their data patterns are complementary. The link answers after delays from zero to several cycles. This separates field capture, direction handling and how long the request is held, and it shows that read data overwrites only on reads. Directed sequences then cover a write that collides with a pending read, the two ways of clearing the collision flag, expiry at an exact cycle count, a limit of zero, and a stray done pulse while idle.

// File: rtl/codec_cmd_pkg.sv
package codec_cmd_pkg;
  localparam int IDX_W    = 7;
  localparam int DAT_W    = 16;
  localparam int REG_W    = 32;
  localparam int IDX_LSB  = DAT_W;
  localparam int RD_BIT   = IDX_LSB + IDX_W;
  localparam int BUSY_BIT = RD_BIT + 1;
  localparam int VLD_BIT  = BUSY_BIT + 1;
  localparam int COLL_BIT = VLD_BIT + 1;
  localparam int PAD_W    = REG_W - COLL_BIT - 1;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [DAT_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/codec_cmd_wdog.sv
module codec_cmd_wdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             done_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R9 R10: expire on the N-th busy cycle, limit 0 never expires
  assign expire_o = run_i && !done_i && (limit_i != '0) &&
                    (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/codec_cmd_reg.sv
module codec_cmd_reg
  import codec_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             done_i,
  input  logic [DAT_W-1:0] rdata_i,
  input  logic             expire_i,
  output logic             accept_o,
  output logic             busy_o,
  output cmd_t             cmd_o,
  output logic [REG_W-1:0] word_o
);
  cmd_t cmd_q;
  logic busy_q, vld_q, coll_q;

  assign accept_o = wr_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      coll_q <= 1'b0;
    end else if (accept_o) begin
      cmd_q.rd   <= wdata_i[RD_BIT];
      cmd_q.idx  <= wdata_i[IDX_LSB +: IDX_W];
      cmd_q.data <= wdata_i[DAT_W-1:0];
      busy_q     <= 1'b1;
      vld_q      <= 1'b0;
      // R8: cleared only by writing 1 to its bit
      coll_q     <= coll_q && !wdata_i[COLL_BIT];
    end else begin
      if (wr_i) coll_q <= 1'b1;
      if (busy_q && done_i) begin
        busy_q <= 1'b0;
        if (cmd_q.rd) begin
          cmd_q.data <= rdata_i;
          vld_q      <= 1'b1;
        end
      end else if (busy_q && expire_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign cmd_o  = cmd_q;
  assign word_o = {{PAD_W{1'b0}}, coll_q, vld_q, busy_q,
                   cmd_q.rd, cmd_q.idx, cmd_q.data};
endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import codec_cmd_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_wr_i,
  input  logic [31:0]      host_wdata_i,
  output logic [31:0]      host_rdata_o,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             link_req_o,
  output logic             link_rd_o,
  output logic [6:0]       link_idx_o,
  output logic [15:0]      link_wdata_o,
  input  logic             link_done_i,
  input  logic [15:0]      link_rdata_i
);
  logic accept, busy, expire;
  cmd_t cmd;

  codec_cmd_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (host_wr_i),
    .wdata_i  (host_wdata_i),
    .done_i   (link_done_i),
    .rdata_i  (link_rdata_i),
    .expire_i (expire),
    .accept_o (accept),
    .busy_o   (busy),
    .cmd_o    (cmd),
    .word_o   (host_rdata_o)
  );

  codec_cmd_wdog #(.TMO_W(TMO_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .run_i    (busy),
    .done_i   (link_done_i),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  assign link_req_o   = busy;
  assign link_rd_o    = cmd.rd;
  assign link_idx_o   = cmd.idx;
  assign link_wdata_o = cmd.data;
endmodule

// File: rtl/codec_cmd_port_chk.sv
module codec_cmd_port_chk
  import codec_cmd_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_wr_i,
  input logic [31:0]      host_rdata_o,
  input logic [TMO_W-1:0] tmo_limit_i,
  input logic             link_req_o,
  input logic             link_rd_o,
  input logic [6:0]       link_idx_o,
  input logic [15:0]      link_wdata_o,
  input logic             link_done_i
);
  logic [TMO_W:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_cnt_q <= '0;
    else if (link_req_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else                 busy_cnt_q <= '0;
  end

  // R2 R6
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_req_o && host_wr_i) |=> (link_req_o && !host_rdata_o[VLD_BIT]));

  // R7
  no_change_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && host_wr_i) |=> ($stable(link_idx_o) && $stable(link_rd_o)));

  // R7
  collision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && host_wr_i) |=> host_rdata_o[COLL_BIT]);

  // R3
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && link_done_i) |=> !link_req_o);

  // R4
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rdata_o[VLD_BIT]) |-> $past(link_req_o && link_done_i && link_rd_o));

  // R5
  write_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && link_done_i && !link_rd_o) |=> !host_rdata_o[VLD_BIT]);

  // R9
  tmo_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && tmo_limit_i != '0) |-> (busy_cnt_q < {1'b0, tmo_limit_i}));

  // R1
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o[31:27] == 5'd0);
endmodule

bind codec_cmd_port codec_cmd_port_chk #(.TMO_W(TMO_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rdata_o (host_rdata_o),
  .tmo_limit_i  (tmo_limit_i),
  .link_req_o   (link_req_o),
  .link_rd_o    (link_rd_o),
  .link_idx_o   (link_idx_o),
  .link_wdata_o (link_wdata_o),
  .link_done_i  (link_done_i)
);

// File: tb/codec_cmd_port_test.sv
module codec_cmd_port_test;
  localparam int TMO_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             host_wr_i = 1'b0;
  logic [31:0]      host_wdata_i = '0;
  logic [31:0]      host_rdata_o;
  logic [TMO_W-1:0] tmo_limit_i = 16'd20;
  logic             link_req_o, link_rd_o;
  logic [6:0]       link_idx_o;
  logic [15:0]      link_wdata_o;
  logic             link_done_i = 1'b0;
  logic [15:0]      link_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  codec_cmd_port #(.TMO_W(TMO_W)) uut (.*);

  typedef struct packed {
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] wd;
    logic [15:0] rsp;
    logic [7:0]  dly;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h00, 16'hA5A5, 16'h0000, 8'd0},
    '{1'b1, 7'h7F, 16'h0000, 16'h5A5A, 8'd3},
    '{1'b0, 7'h7F, 16'hFFFF, 16'h1111, 8'd1},
    '{1'b1, 7'h00, 16'h0000, 16'hFFFF, 8'd0},
    '{1'b1, 7'h2A, 16'h0000, 16'h8001, 8'd9},
    '{1'b0, 7'h55, 16'h0001, 16'hEEEE, 8'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk_i);
    host_wr_i = 1'b1;
    host_wdata_i = w;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic respond(input logic [15:0] d);
    link_done_i = 1'b1;
    link_rdata_i = d;
    @(negedge clk_i);
    link_done_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic c, input logic v, input logic b,
                                     input logic r, input logic [6:0] i,
                                     input logic [15:0] d);
    return {5'd0, c, v, b, r, i, d};
  endfunction

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk_i);
    // R1
    chk(host_rdata_o == 32'd0 && !link_req_o, "R1 reset", host_rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(host_rdata_o == 32'd0, "R1 after release", host_rdata_o, 32'd0);

    for (int k = 0; k < NV; k++) begin
      issue(mk(1'b0, 1'b0, 1'b0, VECS[k].rd, VECS[k].idx, VECS[k].wd));
      // R2
      chk(link_req_o && link_rd_o == VECS[k].rd && link_idx_o == VECS[k].idx &&
          link_wdata_o == VECS[k].wd,
          "R2 link fields", {8'd0, link_rd_o, link_idx_o, link_wdata_o},
          {8'd0, VECS[k].rd, VECS[k].idx, VECS[k].wd});
      chk(host_rdata_o == mk(1'b0, 1'b0, 1'b1, VECS[k].rd, VECS[k].idx, VECS[k].wd),
          "R6 busy word", host_rdata_o,
          mk(1'b0, 1'b0, 1'b1, VECS[k].rd, VECS[k].idx, VECS[k].wd));
      repeat (int'(VECS[k].dly)) @(negedge clk_i);
      // R3
      chk(link_req_o, "R3 held", {31'd0, link_req_o}, 32'd1);
      respond(VECS[k].rsp);
      // R4 R5
      snap = mk(1'b0, VECS[k].rd, 1'b0, VECS[k].rd, VECS[k].idx,
                VECS[k].rd ? VECS[k].rsp : VECS[k].wd);
      chk(host_rdata_o == snap && !link_req_o, VECS[k].rd ? "R4 read done" : "R5 write done",
          host_rdata_o, snap);
    end

    // R7 collision with a pending read
    issue(mk(1'b0, 1'b0, 1'b0, 1'b1, 7'h05, 16'h0000));
    issue(mk(1'b0, 1'b0, 1'b0, 1'b0, 7'h33, 16'h9999));
    chk(link_idx_o == 7'h05 && link_rd_o && link_wdata_o == 16'h0000,
        "R7 fields unchanged", {8'd0, link_rd_o, link_idx_o, link_wdata_o},
        {8'd0, 1'b1, 7'h05, 16'h0000});
    chk(host_rdata_o == mk(1'b1, 1'b0, 1'b1, 1'b1, 7'h05, 16'h0000),
        "R7 collision flag", host_rdata_o, mk(1'b1, 1'b0, 1'b1, 1'b1, 7'h05, 16'h0000));
    respond(16'hBEEF);
    chk(host_rdata_o == mk(1'b1, 1'b1, 1'b0, 1'b1, 7'h05, 16'hBEEF),
        "R4 read after collision", host_rdata_o, mk(1'b1, 1'b1, 1'b0, 1'b1, 7'h05, 16'hBEEF));

    // R8 accepted with bit 26 low keeps flag; R6 valid clears
    issue(mk(1'b0, 1'b0, 1'b0, 1'b0, 7'h10, 16'h1234));
    chk(host_rdata_o == mk(1'b1, 1'b0, 1'b1, 1'b0, 7'h10, 16'h1234),
        "R8 sticky, R6 valid cleared", host_rdata_o, mk(1'b1, 1'b0, 1'b1, 1'b0, 7'h10, 16'h1234));
    respond(16'h0000);
    issue(mk(1'b1, 1'b0, 1'b0, 1'b0, 7'h11, 16'h4321));
    chk(host_rdata_o == mk(1'b0, 1'b0, 1'b1, 1'b0, 7'h11, 16'h4321),
        "R8 cleared by write-one", host_rdata_o, mk(1'b0, 1'b0, 1'b1, 1'b0, 7'h11, 16'h4321));
    respond(16'h0000);

    // R9 timeout at limit 4
    tmo_limit_i = 16'd4;
    issue(mk(1'b0, 1'b0, 1'b0, 1'b1, 7'h22, 16'h00C3));
    repeat (3) @(negedge clk_i);
    chk(link_req_o, "R9 busy on last cycle", {31'd0, link_req_o}, 32'd1);
    @(negedge clk_i);
    chk(host_rdata_o == mk(1'b0, 1'b0, 1'b0, 1'b1, 7'h22, 16'h00C3),
        "R9 expired", host_rdata_o, mk(1'b0, 1'b0, 1'b0, 1'b1, 7'h22, 16'h00C3));

    // R10 limit zero
    tmo_limit_i = 16'd0;
    issue(mk(1'b0, 1'b0, 1'b0, 1'b1, 7'h01, 16'h0000));
    repeat (50) @(negedge clk_i);
    chk(link_req_o, "R10 still pending", {31'd0, link_req_o}, 32'd1);
    respond(16'h7777);
    chk(host_rdata_o == mk(1'b0, 1'b1, 1'b0, 1'b1, 7'h01, 16'h7777),
        "R10 completes", host_rdata_o, mk(1'b0, 1'b1, 1'b0, 1'b1, 7'h01, 16'h7777));

    // R11 stray done
    snap = host_rdata_o;
    respond(16'h1357);
    @(negedge clk_i);
    chk(host_rdata_o == snap && !link_req_o, "R11 idle done ignored", host_rdata_o, snap);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule